// File: doc/BRIEF.md
# Patch Record Chain Walker

This engine decides, once per reset, whether any patch entry in a chain of records held in fuse storage redirects one particular target address. It reads fuse words one at a time through a request/valid port. The walk starts at a fixed top word and moves downward. Each record header gives the number of entries in the record and the size of the next record. The entry words sit directly below the header.

A query is started with a one-cycle `start`. The first query samples a status word and a size word, walks the chain, and ends with a one-cycle `done`. The `match` and `error` results stay cached. A later query gives the same `done` pulse and the same results without any fuse reads. Only a reset clears the cache.

Top module: `patch_chain_walker`

## Requirements
- R1: While reset is held and right after it, `done`, `match`, `error`, `busy` and `rd_req` are all low.
- R2: The first query reads its first header at word 191 (parameter `TOP_WORD`). The first record size is `size_word[6:0]`. If that size is zero, no read is issued, `done` pulses, and the walk ends.
- R3: In a header word, bits [19:16] hold the entry count N. Entry i (0 ≤ i < N) is read from the header address minus (i+1), in increasing order of i.
- R4: An entry's target is its bits [31:16] multiplied by two (a 17-bit value). When the target equals `CMP_ADDR` (default 0x769A), `match` becomes 1 and stays 1 for the rest of the walk.
- R5: After the entries of a record, the address drops by the current record size. The next record size is header bits [31:25]. The walk ends when the record size is zero.
- R6: If bit 7 of `status_word` is set when the first query starts, `match` is 1 whatever the walk finds.
- R7: `rd_req` is a one-cycle pulse. At most one read is outstanding, and the next request comes only after the `rd_valid` of the previous one.
- R8: If an entry count exceeds the current address, or a record size exceeds the current address, the walk stops with `error` = 1 and a `done` pulse. No further reads follow.
- R9: `done` is high for exactly one cycle per query. After the first query completes, `match` and `error` never change until reset.
- R10: A query after the first completed one gives `done` in the cycle after `start`, with the cached `match` and `error` and no read. A reset clears the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle query request |
| size_word | input | WORD_W | Patch size word; low 7 bits give the first record size |
| status_word | input | WORD_W | Reserved status word; bit 7 forces a match |
| rd_req | output | 1 | One-cycle fuse read request |
| rd_addr | output | ADDR_W | Fuse word address for the read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | WORD_W | Read data |
| busy | output | 1 | A query is being handled |
| done | output | 1 | One-cycle end-of-query pulse |
| match | output | 1 | Cached result: a patch targets the compare address |
| error | output | 1 | Cached result: the walk aborted on address underflow |

## Verification
A wrong internal address or index shows at the ports right away: the `rd_addr` of the next request goes to the wrong fuse word. The bench logs and compares every requested address in order. A wrong count or link field shows a few cycles later, as an extra read, a missing read or an early `done`. A corrupted cache shows on the next query, as a read where none should occur or as a changed `match`. A broken doubling or comparison shows only at the final `match` value, so stored targets are chosen to tell the doubled value from the raw one.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  localparam int CNT_LSB  = 16;
  localparam int CNT_W    = 4;
  localparam int LINK_LSB = 25;
  localparam int LINK_W   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_HDR_REQ,
    ST_HDR_WAIT,
    ST_ENT_REQ,
    ST_ENT_WAIT,
    ST_ADVANCE,
    ST_FINISH
  } walk_state_t;
endpackage

// File: rtl/pcw_hdr_decode.sv
module pcw_hdr_decode
  import pcw_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  ent_cnt,
  output logic [LINK_W-1:0] link_size
);
  assign ent_cnt   = word[CNT_LSB +: CNT_W];
  assign link_size = word[LINK_LSB +: LINK_W];
endmodule

// File: rtl/pcw_entry_match.sv
module pcw_entry_match #(
  parameter int WORD_W = 32,
  parameter int TGT_W  = WORD_W/2 + 1,
  parameter logic [TGT_W-1:0] CMP_ADDR = 'h769A
) (
  input  logic [WORD_W-1:0] word,
  output logic              hit
);
  localparam int HALF_W = WORD_W/2;
  logic [TGT_W-1:0] target;
  // halfword index to byte address
  assign target = {word[WORD_W-1 -: HALF_W], 1'b0};
  assign hit    = (target == CMP_ADDR);
endmodule

// File: rtl/pcw_result_reg.sv
module pcw_result_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic walk_begin,
  input  logic pre_flag,
  input  logic hit_en,
  input  logic err_set,
  input  logic fin_set,
  output logic match_q,
  output logic err_q,
  output logic checked_q
);
  logic match_d, err_d, checked_d;

  always_comb begin
    match_d   = match_q;
    err_d     = err_q;
    checked_d = checked_q;
    if (walk_begin) begin
      match_d = pre_flag;
      err_d   = 1'b0;
    end else begin
      if (hit_en)  match_d   = 1'b1;
      if (err_set) err_d     = 1'b1;
      if (fin_set) checked_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q   <= 1'b0;
      err_q     <= 1'b0;
      checked_q <= 1'b0;
    end else begin
      match_q   <= match_d;
      err_q     <= err_d;
      checked_q <= checked_d;
    end
  end

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    checked_q |=> ($stable(match_q) && $stable(err_q) && checked_q));
endmodule

// File: rtl/patch_chain_walker.sv
module patch_chain_walker
  import pcw_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int TOP_WORD  = 191,
  parameter int FLAG_BIT  = 7,
  parameter int TGT_W     = WORD_W/2 + 1,
  parameter logic [TGT_W-1:0] CMP_ADDR = 'h769A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] size_word,
  input  logic [WORD_W-1:0] status_word,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              match,
  output logic              error
);
  localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(TOP_WORD);

  walk_state_t state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [LINK_W-1:0] size_q, link_q;
  logic [CNT_W-1:0]  cnt_q, idx_q;

  logic [CNT_W-1:0]  hdr_cnt;
  logic [LINK_W-1:0] hdr_link;
  logic              ent_hit;
  logic              checked;

  logic ld_start, ld_hdr, inc_idx, ld_adv;
  logic walk_begin, hit_en, err_set, fin_set;
  logic last_ent;

  pcw_hdr_decode #(.WORD_W(WORD_W)) u_hdr (
    .word(rd_data), .ent_cnt(hdr_cnt), .link_size(hdr_link)
  );

  pcw_entry_match #(.WORD_W(WORD_W), .TGT_W(TGT_W), .CMP_ADDR(CMP_ADDR)) u_ent (
    .word(rd_data), .hit(ent_hit)
  );

  pcw_result_reg u_res (
    .clk(clk), .rst_n(rst_n),
    .walk_begin(walk_begin), .pre_flag(status_word[FLAG_BIT]),
    .hit_en(hit_en), .err_set(err_set), .fin_set(fin_set),
    .match_q(match), .err_q(error), .checked_q(checked)
  );

  assign last_ent = ({1'b0, idx_q} + 1'b1) == {1'b0, cnt_q};

  always_comb begin
    state_d    = state_q;
    rd_req     = 1'b0;
    rd_addr    = addr_q;
    ld_start   = 1'b0;
    ld_hdr     = 1'b0;
    inc_idx    = 1'b0;
    ld_adv     = 1'b0;
    walk_begin = 1'b0;
    hit_en     = 1'b0;
    err_set    = 1'b0;
    fin_set    = 1'b0;
    done       = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        if (checked) begin
          state_d = ST_FINISH;
        end else begin
          ld_start   = 1'b1;
          walk_begin = 1'b1;
          state_d    = ST_CHECK;
        end
      end
      ST_CHECK: state_d = (size_q == '0) ? ST_FINISH : ST_HDR_REQ;
      ST_HDR_REQ: begin
        rd_req  = 1'b1;
        state_d = ST_HDR_WAIT;
      end
      ST_HDR_WAIT: if (rd_valid) begin
        ld_hdr = 1'b1;
        if (ADDR_W'(hdr_cnt) > addr_q) begin
          err_set = 1'b1;
          state_d = ST_FINISH;
        end else if (hdr_cnt == '0) begin
          state_d = ST_ADVANCE;
        end else begin
          state_d = ST_ENT_REQ;
        end
      end
      ST_ENT_REQ: begin
        rd_req  = 1'b1;
        rd_addr = addr_q - ADDR_W'(idx_q) - ADDR_W'(1);
        state_d = ST_ENT_WAIT;
      end
      ST_ENT_WAIT: if (rd_valid) begin
        hit_en  = ent_hit;
        inc_idx = 1'b1;
        state_d = last_ent ? ST_ADVANCE : ST_ENT_REQ;
      end
      ST_ADVANCE: begin
        if (ADDR_W'(size_q) > addr_q) begin
          err_set = 1'b1;
          state_d = ST_FINISH;
        end else begin
          ld_adv  = 1'b1;
          state_d = ST_CHECK;
        end
      end
      ST_FINISH: begin
        done    = 1'b1;
        fin_set = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      size_q  <= '0;
      link_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ld_start) begin
        addr_q <= TOP_A;
        size_q <= size_word[LINK_W-1:0];
      end else if (ld_adv) begin
        addr_q <= addr_q - ADDR_W'(size_q);
        size_q <= link_q;
      end
      if (ld_hdr) begin
        cnt_q  <= hdr_cnt;
        link_q <= hdr_link;
        idx_q  <= '0;
      end else if (inc_idx) begin
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  // R10
  cached_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    checked |-> !rd_req);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr <= TOP_A));
  // R8
  err_ends_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set) |=> (done && !rd_req));
endmodule

// File: tb/sim_patch_chain_walker.sv
`timescale 1ns/1ps
module sim_patch_chain_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] size_word = '0;
  logic [31:0] status_word = '0;
  logic        rd_req;
  logic [7:0]  rd_addr;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        busy, done, match, error;

  int checks = 0;
  int errors = 0;

  logic [31:0] fmem [0:255];
  int          nrd = 0;
  int          ovl = 0;
  logic [7:0]  rlog [0:63];
  logic        pend = 1'b0;
  logic [7:0]  paddr = '0;
  int          lat = 0;

  always #2 clk = ~clk;

  patch_chain_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .size_word(size_word), .status_word(status_word),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .match(match), .error(error)
  );

  // fuse model: answers two cycles after a request
  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (rd_req) begin
      if (pend) ovl = ovl + 1;
      rlog[nrd % 64] = rd_addr;
      nrd = nrd + 1;
      pend  <= 1'b1;
      paddr <= rd_addr;
      lat   <= 2;
    end else if (pend) begin
      if (lat == 1) begin
        rd_valid <= 1'b1;
        rd_data  <= fmem[paddr];
        pend     <= 1'b0;
      end else begin
        lat <= lat - 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) fmem[i] = 32'h0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // issues a query and waits for done; returns read count and done width
  task automatic query(input logic [31:0] sz, input logic [31:0] st,
                       output int reads, output int base, output int dwidth);
    int t;
    base = nrd;
    @(negedge clk);
    size_word = sz;
    status_word = st;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 1000) begin
      @(negedge clk);
      t++;
    end
    dwidth = 0;
    while (done && dwidth < 5) begin
      dwidth++;
      @(negedge clk);
    end
    reads = nrd - base;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 done", done, 0);
    chk("R1 match", match, 0);
    chk("R1 error", error, 0);
    chk("R1 busy", busy, 0);
    chk("R1 rd_req", rd_req, 0);
  endtask

  task automatic t_empty();
    int r, b, w;
    clear_mem();
    do_reset();
    query(32'hFFFF_FF80, 32'h0, r, b, w);
    chk("R2 zero size reads", r, 0);
    chk("R9 done width", w, 1);
    chk("R2 match", match, 0);
    chk("R8 error", error, 0);
  endtask

  task automatic t_status();
    int r, b, w;
    clear_mem();
    do_reset();
    query(32'h0, 32'h0000_0080, r, b, w);
    chk("R6 forced match", match, 1);
    chk("R6 reads", r, 0);
  endtask

  task automatic build_chain(input logic [31:0] last_entry);
    clear_mem();
    fmem[191] = (32'd3 << 25) | (32'd2 << 16);
    fmem[190] = 32'h1234_0000;
    fmem[189] = 32'h0001_0000;
    fmem[186] = (32'd0 << 25) | (32'd1 << 16);
    fmem[185] = last_entry;
  endtask

  task automatic t_chain_hit();
    int r, b, w;
    build_chain(32'h3B4D_0000);
    do_reset();
    query(32'hABCD_0005, 32'h0, r, b, w);
    chk("R5 read count", r, 5);
    chk("R2 first header", rlog[b % 64], 191);
    chk("R3 entry 0", rlog[(b+1) % 64], 190);
    chk("R3 entry 1", rlog[(b+2) % 64], 189);
    chk("R5 next header", rlog[(b+3) % 64], 186);
    chk("R3 next entry", rlog[(b+4) % 64], 185);
    chk("R4 match", match, 1);
    chk("R8 no error", error, 0);
    chk("R9 done width", w, 1);
    chk("R7 one outstanding", ovl, 0);
    // cached query without reset
    fmem[185] = 32'h0;
    query(32'h0000_0005, 32'h0, r, b, w);
    chk("R10 cached reads", r, 0);
    chk("R10 cached match", match, 1);
    chk("R10 cached done", w, 1);
    repeat (4) @(negedge clk);
    chk("R9 match stable", match, 1);
  endtask

  task automatic t_chain_miss();
    int r, b, w;
    // raw halfword equals compare value: doubled it must not match
    build_chain(32'h769A_0000);
    do_reset();
    chk("R10 reset clears", match, 0);
    query(32'h0000_0005, 32'h0, r, b, w);
    chk("R4 no match raw", match, 0);
    chk("R5 read count", r, 5);
    build_chain(32'h3B4C_0000);
    do_reset();
    query(32'h0000_0005, 32'h0000_0080, r, b, w);
    chk("R6 match with walk miss", match, 1);
  endtask

  task automatic t_underflow();
    int r, b, w;
    clear_mem();
    fmem[191] = (32'd100 << 25);
    do_reset();
    query(32'h0000_0078, 32'h0, r, b, w);
    chk("R8 error", error, 1);
    chk("R8 reads", r, 2);
    chk("R8 second header", rlog[(b+1) % 64], 71);
    chk("R8 match", match, 0);
    chk("R9 done width", w, 1);
    repeat (3) @(negedge clk);
    chk("R8 no more reads", nrd - b, 2);
    chk("R9 error held", error, 1);
  endtask

  initial begin
    t_reset();
    t_empty();
    t_status();
    t_chain_hit();
    t_chain_miss();
    t_underflow();
    chk("R7 overlap total", ovl, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule